// File: doc/BRIEF.md
# Two-Stage System Watchdog Timer

A single watchdog serves the whole multi-core system; it is instantiated once, not once per core. Software arms it with a watch period and must prove it is alive by writing a key value to a refresh register before the period runs out. A refresh restarts the period from its beginning. If the period runs out with no refresh, a warning output rises and a second watch period starts at once. The warning output is meant to drive an interrupt.

Software can recover during the second period by refreshing the timer. That drops the warning and returns the timer to normal counting. If the second period also runs out, a final output rises and stays high until system reset. The final output is meant to drive a reset generator or a higher-privilege agent. A single-stage mode skips the warning: the first expiry raises the final output directly.

Top module: `sys_watchdog`

## Requirements
- R1: After reset, both timeout outputs are low, the control and status registers read 0, and the period register reads the RST_PERIOD parameter.
- R2: The register map uses byte offsets. 0x0 is control: bit 0 enable, bit 1 single-stage. 0x4 is the period. 0x8 is refresh: write-only, reads 0. 0xC is status: bit 0 warning, bit 1 final, read-only. Read data is combinational from the address.
- R3: A control write that turns enable from 0 to 1 loads the period P. The warning output rises on the (P+1)th rising edge after the edge that captures that write, one cycle after the counter reaches zero.
- R4: Writing 0x5A5A5A5A to the refresh register while enabled restarts the count. The warning output then rises P+1 edges after the refresh edge.
- R5: A refresh write with any other value has no effect on the count or on the outputs.
- R6: With no refresh in the warning stage, the final output rises P+1 edges after the warning rose, and the warning output falls on that same edge.
- R7: A valid refresh in the warning stage drops the warning output on the refresh edge and starts a fresh period in the normal stage.
- R8: Once the final output is high, it stays high until reset. Neither refresh writes nor disabling the timer clear it.
- R9: In single-stage mode, the first expiry raises the final output P+1 edges after the enable or refresh, and the warning output never rises.
- R10: While disabled, the counter holds and the warning output is low. Disabling the timer in the warning stage clears the warning within two edges.
- R11: A period write takes effect only at the next reload, meaning an enable, a refresh or the start of the warning stage, and never in the middle of a running period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous system reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register byte offset |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data, combinational |
| wdt_warn_o | output | 1 | First-stage timeout level, for an interrupt |
| wdt_final_o | output | 1 | Second-stage timeout level, sticky |

## Verification
Every timed result is counted in rising edges from the edge that captures the enabling or refresh write. With P loaded, the warning is due on edge P+1 and the final output on edge 2P+2; in single-stage mode the final output is due on edge P+1. The bench drives each write half a cycle before its capture edge and then waits an exact number of edges. It samples one time unit after the edge, checking the last cycle before each output is due as well as the cycle it is due. The random part predicts both outputs from a function of the edge count, the period and the mode. Register reads and ignored refreshes are checked in the cycle after the write.

// File: rtl/wdog_pkg.sv
`timescale 1ns/1ps
package wdog_pkg;
  localparam int ADDR_W = 4;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_WARN  = 2'd1,
    ST_FINAL = 2'd2
  } wd_stage_e;

  localparam logic [ADDR_W-1:0] OFF_CTRL   = 4'h0;
  localparam logic [ADDR_W-1:0] OFF_PERIOD = 4'h4;
  localparam logic [ADDR_W-1:0] OFF_KICK   = 4'h8;
  localparam logic [ADDR_W-1:0] OFF_STAT   = 4'hC;

  localparam logic [31:0] KICK_KEY = 32'h5A5A_5A5A;
endpackage

// File: rtl/wdog_regs.sv
`timescale 1ns/1ps
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int                DATA_W     = 32,
  parameter logic [DATA_W-1:0] RST_PERIOD = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  wd_stage_e         stage_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              en_o,
  output logic              single_o,
  output logic [DATA_W-1:0] period_o,
  output logic              kick_o,
  output logic              start_o
);
  logic              en_q, single_q;
  logic [DATA_W-1:0] period_q;
  logic              wr_ctrl, wr_period;

  assign wr_ctrl   = we_i && (addr_i == OFF_CTRL);
  assign wr_period = we_i && (addr_i == OFF_PERIOD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= 1'b0;
      single_q <= 1'b0;
      period_q <= RST_PERIOD;
    end else begin
      if (wr_ctrl) begin
        en_q     <= wdata_i[0];
        single_q <= wdata_i[1];
      end
      if (wr_period) period_q <= wdata_i;
    end
  end

  // only the exact key counts as a refresh
  assign kick_o  = we_i && (addr_i == OFF_KICK) && (wdata_i == DATA_W'(KICK_KEY));
  assign start_o = wr_ctrl && wdata_i[0] && !en_q;

  assign en_o     = en_q;
  assign single_o = single_q;
  assign period_o = period_q;

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFF_CTRL:   rdata_o[1:0] = {single_q, en_q};
      OFF_PERIOD: rdata_o      = period_q;
      OFF_STAT:   rdata_o[1:0] = {stage_i == ST_FINAL, stage_i == ST_WARN};
      default:    rdata_o      = '0;
    endcase
  end

  p_period_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_period |=> period_o == $past(wdata_i));

  p_ctrl_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ctrl |=> {single_o, en_o} == $past(wdata_i[1:0]));
endmodule

// File: rtl/wdog_cnt.sv
`timescale 1ns/1ps
module wdog_cnt #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         run_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (load_i)             cnt_q <= load_val_i;
    else if (run_i && !zero_o)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  p_reload_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == $past(load_val_i));

  p_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !load_i && !zero_o) |=> cnt_q == $past(cnt_q) - 1'b1);

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !load_i) |=> $stable(cnt_q));
endmodule

// File: rtl/wdog_stage.sv
`timescale 1ns/1ps
module wdog_stage
  import wdog_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      en_i,
  input  logic      single_i,
  input  logic      kick_i,
  input  logic      expire_i,
  output wd_stage_e stage_o,
  output logic      warn_o,
  output logic      final_o
);
  wd_stage_e stage_q, stage_d;

  always_comb begin
    stage_d = stage_q;
    if (stage_q != ST_FINAL) begin
      if (!en_i)         stage_d = ST_RUN;
      else if (kick_i)   stage_d = ST_RUN;
      else if (expire_i) stage_d = (stage_q == ST_WARN || single_i) ? ST_FINAL : ST_WARN;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= ST_RUN;
    else         stage_q <= stage_d;
  end

  assign stage_o = stage_q;
  assign warn_o  = (stage_q == ST_WARN);
  assign final_o = (stage_q == ST_FINAL);

  p_final_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    final_o |=> final_o);

  p_kick_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kick_i && warn_o) |=> !warn_o && !final_o);

  p_escalate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_i && warn_o && en_i && !kick_i) |=> final_o && !warn_o);

  p_single_skip_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_i && single_i && en_i && !kick_i && stage_q == ST_RUN) |=> final_o);
endmodule

// File: rtl/sys_watchdog.sv
`timescale 1ns/1ps
module sys_watchdog
  import wdog_pkg::*;
#(
  parameter int                DATA_W     = 32,
  parameter logic [DATA_W-1:0] RST_PERIOD = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [3:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              wdt_warn_o,
  output logic              wdt_final_o
);
  logic              en, single, kick, start, zero;
  logic              kick_ok, expire, reload, run;
  logic [DATA_W-1:0] period;
  wd_stage_e         stage;

  wdog_regs #(.DATA_W(DATA_W), .RST_PERIOD(RST_PERIOD)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (reg_we_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .stage_i  (stage),
    .rdata_o  (reg_rdata_o),
    .en_o     (en),
    .single_o (single),
    .period_o (period),
    .kick_o   (kick),
    .start_o  (start)
  );

  assign kick_ok = kick && en && (stage != ST_FINAL);
  assign run     = en && (stage != ST_FINAL);
  assign expire  = run && zero && !kick_ok;
  // new period is sampled only here: enable, refresh, or entry into the warning stage
  assign reload  = start || kick_ok || (expire && stage == ST_RUN && !single);

  wdog_cnt #(.W(DATA_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (reload),
    .load_val_i (period),
    .run_i      (run),
    .zero_o     (zero)
  );

  wdog_stage u_stage (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en),
    .single_i (single),
    .kick_i   (kick_ok),
    .expire_i (expire),
    .stage_o  (stage),
    .warn_o   (wdt_warn_o),
    .final_o  (wdt_final_o)
  );

  p_quiet_when_off_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en && !wdt_final_o) |=> !wdt_warn_o);

  p_single_no_warn_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (single && en && !wdt_warn_o) |=> !wdt_warn_o);
endmodule

// File: tb/sys_watchdog_bench.sv
`timescale 1ns/1ps
module sys_watchdog_bench;
  localparam int          DW   = 32;
  localparam logic [31:0] RSTP = 32'd40;
  localparam logic [31:0] KEY  = 32'h5A5A_5A5A;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          we = 1'b0;
  logic [3:0]    addr = 4'h0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          warn, fin;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 1'b0;

  sys_watchdog #(.DATA_W(DW), .RST_PERIOD(RSTP)) u_sys_watchdog (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .reg_we_i    (we),
    .reg_addr_i  (addr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .wdt_warn_o  (warn),
    .wdt_final_o (fin)
  );

  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    #1 we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    we = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  // expected {final,warn} g edges after a load of period p
  function automatic logic [1:0] exp_out(input int g, input int p, input bit single);
    if (g <= p) return 2'b00;
    if (single) return 2'b10;
    if (g <= 2*p + 1) return 2'b01;
    return 2'b10;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: got hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'd20240607));
    do_reset();

    // R1 reset state
    check("R1 warn", {31'b0, warn}, 0);
    check("R1 final", {31'b0, fin}, 0);
    rd(4'h0, r); check("R1 ctrl", r, 0);
    rd(4'h4, r); check("R1 period", r, RSTP);
    rd(4'hC, r); check("R1 status", r, 0);

    // R2 register map
    wr(4'h0, 32'h2); rd(4'h0, r); check("R2 ctrl single", r, 32'h2);
    wr(4'h0, 32'h0);
    wr(4'h4, 32'd7); rd(4'h4, r); check("R2 period", r, 32'd7);
    wr(4'h8, KEY);   rd(4'h8, r); check("R2 refresh reads 0", r, 0);

    // R3 enable timing, P=7
    wr(4'h0, 32'h1);
    edges(7);  check("R3 warn before", {31'b0, warn}, 0);
    edges(1);  check("R3 warn due", {31'b0, warn}, 1);
    rd(4'hC, r); check("R2 status warn", r, 32'h1);

    // R7 refresh during warning
    wr(4'h8, KEY);
    check("R7 warn dropped", {31'b0, warn}, 0);
    // R4 restart from refresh edge
    edges(7);  check("R4 warn before", {31'b0, warn}, 0);
    edges(1);  check("R4 warn due", {31'b0, warn}, 1);

    // R5 bad key ignored, R6 escalation
    wr(4'h8, 32'h5A5A_5A5B);
    check("R5 warn kept", {31'b0, warn}, 1);
    edges(6);
    check("R6 final before", {31'b0, fin}, 0);
    check("R5 warn still", {31'b0, warn}, 1);
    edges(1);
    check("R6 final due", {31'b0, fin}, 1);
    check("R6 warn falls", {31'b0, warn}, 0);

    // R8 sticky final
    wr(4'h8, KEY);
    check("R8 refresh no clear", {31'b0, fin}, 1);
    wr(4'h0, 32'h0);
    edges(3);
    check("R8 disable no clear", {31'b0, fin}, 1);
    rd(4'hC, r); check("R8 status final", r, 32'h2);
    do_reset();
    check("R8 reset clears", {31'b0, fin}, 0);

    // R9 single-stage
    wr(4'h4, 32'd5);
    wr(4'h0, 32'h3);
    edges(5); check("R9 final before", {30'b0, fin, warn}, 0);
    edges(1); check("R9 final direct", {30'b0, fin, warn}, 32'h2);

    // R10 disable in warning, then hold
    do_reset();
    wr(4'h4, 32'd5);
    wr(4'h0, 32'h1);
    edges(6); check("R10 warn up", {31'b0, warn}, 1);
    wr(4'h0, 32'h0);
    edges(2); check("R10 warn cleared", {30'b0, fin, warn}, 0);
    wr(4'h8, KEY);
    edges(20); check("R10 held quiet", {30'b0, fin, warn}, 0);

    // R11 period change mid-period
    do_reset();
    wr(4'h4, 32'd10);
    wr(4'h0, 32'h1);
    edges(1);
    wr(4'h4, 32'd4);
    edges(8); check("R11 old period kept", {31'b0, warn}, 0);
    edges(1); check("R11 warn on old period", {31'b0, warn}, 1);
    edges(4); check("R11 final before", {31'b0, fin}, 0);
    edges(1); check("R11 new period on reload", {31'b0, fin}, 1);

    // random: enable, optional refresh (maybe bad key), predict outputs
    for (int it = 0; it < 24; it++) begin
      int  p, g1, g2, g;
      bit  single, good;
      p      = 3 + int'($urandom % 13);
      single = ($urandom % 4) == 0;
      good   = ($urandom % 3) != 0;
      g1     = int'($urandom % (p + 1));
      g2     = int'($urandom % (2*p + 6));
      do_reset();
      wr(4'h4, p);
      wr(4'h0, {30'b0, single, 1'b1});
      edges(g1);
      wr(4'h8, good ? KEY : (KEY ^ (32'h1 << ($urandom % 32))));
      edges(g2);
      g = good ? g2 : (g1 + 1 + g2);
      check(good ? "R4 random refresh" : "R5 random bad key",
            {30'b0, fin, warn}, {30'b0, exp_out(g, p, single)});
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule